// File: doc/BRIEF.md
# Sixteen-bit Minicomputer ALU with Condition Codes

This block is the arithmetic and logic stage of a minicomputer-style processor. It supports fourteen single-operand operations and eight double-operand operations. Each operation runs on a full word or on the low byte. On every valid cycle it takes an operation code, a source operand, a destination operand, a byte flag and the current four condition codes. One clock later it returns the result, the new condition codes and a flag that says whether the result should be written back.

Single-operand operations act on the destination operand. Each operation has its own rule for the condition codes. Some keep the carry. The shifts derive overflow from the new sign and carry. Compare, bit-test and test produce flags only. Byte swap and sign extend always act on the whole word and set their flags in their own way. The surrounding decoder handles addressing, traps and memory; this block sees only operand values.

Top module: `mmalu`

## Requirements
- R1: After reset, out_valid, out_wr, out_result and out_cc are all zero. A request accepted with in_valid high produces its outputs exactly one clock later with out_valid high. A cycle with in_valid low produces out_valid low one clock later.
- R2: Condition code bits are N=bit 3, Z=bit 2, V=bit 1, C=bit 0. The operation codes are: CLR 0, COM 1, INC 2, DEC 3, NEG 4, TST 5, ROR 6, ROL 7, ASR 8, ASL 9, ADC 10, SBC 11, SWAB 12, SXT 13, MOV 16, CMP 17, BIT 18, BIC 19, BIS 20, ADD 21, SUB 22, XOR 23. Unless a rule below says otherwise, N is the top bit of the result and Z is set when the result is zero.
- R3: CMP, BIT and TST never write: out_wr is 0 and out_result equals the destination. CMP takes flags from source minus destination, with C set on borrow and V set on signed overflow. TST clears V and C.
- R4: INC and DEC keep C. V is set only when the operand is the largest positive value (INC) or the most negative value (DEC).
- R5: COM gives V=0 and C=1. NEG gives C=1 for a nonzero result and V=1 only when the result is the most negative value.
- R6: ROR and ROL rotate through C. ASR shifts right and replicates the sign. ASL shifts left and fills with 0. In all four, C takes the bit shifted out and V equals N xor C of the result.
- R7: ADC adds the incoming C and SBC subtracts it. ADC sets C on carry out. SBC sets C on borrow. V is set on signed overflow.
- R8: ADD gives source plus destination, with C on carry out. SUB gives destination minus source, with C on borrow. Both set V on signed overflow.
- R9: MOV, BIT, BIC (destination AND NOT source), BIS and XOR clear V and keep C. CLR gives zero with flags N=0, Z=1, V=0, C=0.
- R10: SWAB exchanges the two bytes of the word. N and Z come from the new low byte only, and V and C are cleared.
- R11: SXT writes all ones when the incoming N is 1 and all zeros otherwise. It keeps N and C, sets Z for a zero result and clears V.
- R12: With in_byte set, every operation except SWAB and SXT works on the low 8 bits. N comes from bit 7, and carries and shifted-out bits come from the byte. The upper byte of out_result equals the upper byte of the destination. SWAB and SXT ignore in_byte.
- R13: An undefined operation code (14, 15, or 24 to 31) gives out_wr=0, out_result equal to the destination, and out_cc equal to in_cc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 5 | Operation code |
| in_byte | input | 1 | Byte operand size when 1 |
| in_src | input | WORD_W | Source operand |
| in_dst | input | WORD_W | Destination operand (the single operand of one-operand operations) |
| in_cc | input | 4 | Current N, Z, V, C |
| out_valid | output | 1 | Outputs below belong to the request of the previous cycle |
| out_result | output | WORD_W | Result value |
| out_cc | output | 4 | New N, Z, V, C |
| out_wr | output | 1 | Result should be written back |

## Verification
The bound checker enforces, on every request, several rules that hold for any operand value. It checks the one-cycle valid timing and that compare, bit-test and test never write. It checks that INC, DEC and the logical operations keep C, that COM sets V and C to fixed values, and that V equals N xor C after the shifts. It also checks the SWAB flag rule, that the upper byte is preserved in byte mode, and that undefined codes pass the condition codes through.

Only the bench's operand tables can show that the values themselves are right. These cases include the exact sums and borrows, the overflow boundaries of INC, DEC, NEG, ADC and SBC, the carry into and out of the rotates, and the full-word behaviour of SWAB and SXT when the byte flag is set.

// File: rtl/mmalu_pkg.sv
package mmalu_pkg;

   typedef enum logic [4:0] {
      OP_CLR  = 5'd0,
      OP_COM  = 5'd1,
      OP_INC  = 5'd2,
      OP_DEC  = 5'd3,
      OP_NEG  = 5'd4,
      OP_TST  = 5'd5,
      OP_ROR  = 5'd6,
      OP_ROL  = 5'd7,
      OP_ASR  = 5'd8,
      OP_ASL  = 5'd9,
      OP_ADC  = 5'd10,
      OP_SBC  = 5'd11,
      OP_SWAB = 5'd12,
      OP_SXT  = 5'd13,
      OP_MOV  = 5'd16,
      OP_CMP  = 5'd17,
      OP_BIT  = 5'd18,
      OP_BIC  = 5'd19,
      OP_BIS  = 5'd20,
      OP_ADD  = 5'd21,
      OP_SUB  = 5'd22,
      OP_XOR  = 5'd23
   } alu_op_e;

   localparam int CC_N = 3;
   localparam int CC_Z = 2;
   localparam int CC_V = 1;
   localparam int CC_C = 0;

endpackage

// File: rtl/mmalu_arith.sv
// One shared carry chain. Operand steering turns every add/subtract
// variant into a + b + ci, so one overflow rule covers them all.
module mmalu_arith
   import mmalu_pkg::*;
#(
   parameter int W = 16
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   src,
   input  logic [W-1:0]   dst,
   input  logic           cin,
   output logic [W-1:0]   sum,
   output logic           co,
   output logic           ovf
);

   logic [W-1:0] opa;
   logic [W-1:0] opb;
   logic         ci;
   logic [W:0]   full;

   always_comb begin
      opa = dst;
      opb = '0;
      ci  = 1'b0;
      case (op)
         OP_INC: ci = 1'b1;
         OP_DEC: opb = '1;
         OP_NEG: begin
            opa = '0;
            opb = ~dst;
            ci  = 1'b1;
         end
         OP_ADC: ci = cin;
         OP_SBC: begin
            opb = '1;
            ci  = ~cin;
         end
         OP_ADD: begin
            opa = src;
            opb = dst;
         end
         OP_SUB: begin
            opb = ~src;
            ci  = 1'b1;
         end
         OP_CMP: begin
            opa = src;
            opb = ~dst;
            ci  = 1'b1;
         end
         default: ;
      endcase
   end

   assign full = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, ci};
   assign sum  = full[W-1:0];
   assign co   = full[W];
   assign ovf  = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);

endmodule

// File: rtl/mmalu_shift.sv
module mmalu_shift
   import mmalu_pkg::*;
#(
   parameter int W = 16
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   dst,
   input  logic           cin,
   output logic [W-1:0]   res,
   output logic           cout
);

   always_comb begin
      res  = dst;
      cout = 1'b0;
      case (op)
         OP_ROR: begin
            res  = {cin, dst[W-1:1]};
            cout = dst[0];
         end
         OP_ROL: begin
            res  = {dst[W-2:0], cin};
            cout = dst[W-1];
         end
         OP_ASR: begin
            res  = {dst[W-1], dst[W-1:1]};
            cout = dst[0];
         end
         OP_ASL: begin
            res  = {dst[W-2:0], 1'b0};
            cout = dst[W-1];
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/mmalu_lane.sv
// One operand-size lane: all width-dependent operations for width W.
module mmalu_lane
   import mmalu_pkg::*;
#(
   parameter int W = 16
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   src,
   input  logic [W-1:0]   dst,
   input  logic [3:0]     cc_in,
   output logic [W-1:0]   val,
   output logic [3:0]     cc_out,
   output logic           wr
);

   logic [W-1:0] a_sum;
   logic         a_co;
   logic         a_ovf;
   logic [W-1:0] s_res;
   logic         s_co;
   logic         known;
   logic         v_f;
   logic         c_f;

   mmalu_arith #(.W(W)) u_arith (
      .op  (op),
      .src (src),
      .dst (dst),
      .cin (cc_in[CC_C]),
      .sum (a_sum),
      .co  (a_co),
      .ovf (a_ovf)
   );

   mmalu_shift #(.W(W)) u_shift (
      .op   (op),
      .dst  (dst),
      .cin  (cc_in[CC_C]),
      .res  (s_res),
      .cout (s_co)
   );

   always_comb begin
      val   = dst;
      wr    = 1'b0;
      known = 1'b1;
      v_f   = 1'b0;
      c_f   = cc_in[CC_C];
      case (op)
         OP_CLR: begin
            val = '0;
            wr  = 1'b1;
            c_f = 1'b0;
         end
         OP_COM: begin
            val = ~dst;
            wr  = 1'b1;
            c_f = 1'b1;
         end
         OP_INC, OP_DEC: begin
            val = a_sum;
            wr  = 1'b1;
            v_f = a_ovf;
         end
         OP_NEG: begin
            val = a_sum;
            wr  = 1'b1;
            v_f = a_ovf;
            c_f = ~a_co;
         end
         OP_TST: c_f = 1'b0;
         OP_ROR, OP_ROL, OP_ASR, OP_ASL: begin
            val = s_res;
            wr  = 1'b1;
            c_f = s_co;
            v_f = s_res[W-1] ^ s_co;
         end
         OP_ADC, OP_ADD: begin
            val = a_sum;
            wr  = 1'b1;
            v_f = a_ovf;
            c_f = a_co;
         end
         OP_SBC, OP_SUB: begin
            val = a_sum;
            wr  = 1'b1;
            v_f = a_ovf;
            c_f = ~a_co;
         end
         OP_CMP: begin
            val = a_sum;
            v_f = a_ovf;
            c_f = ~a_co;
         end
         OP_MOV: begin
            val = src;
            wr  = 1'b1;
         end
         OP_BIT: val = src & dst;
         OP_BIC: begin
            val = ~src & dst;
            wr  = 1'b1;
         end
         OP_BIS: begin
            val = src | dst;
            wr  = 1'b1;
         end
         OP_XOR: begin
            val = src ^ dst;
            wr  = 1'b1;
         end
         default: known = 1'b0;
      endcase
      cc_out = known ? {val[W-1], (val == '0), v_f, c_f} : cc_in;
   end

endmodule

// File: rtl/mmalu.sv
module mmalu
   import mmalu_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int REG_OUT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [4:0]        in_op,
   input  logic              in_byte,
   input  logic [WORD_W-1:0] in_src,
   input  logic [WORD_W-1:0] in_dst,
   input  logic [3:0]        in_cc,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_result,
   output logic [3:0]        out_cc,
   output logic              out_wr
);

   localparam int H = WORD_W / 2;

   generate
      if (WORD_W < 8 || (WORD_W % 2) != 0) begin : g_bad_width
         $error("mmalu: WORD_W must be even and at least 8");
      end
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
         $error("mmalu: REG_OUT must be 0 or 1");
      end
   endgenerate

   alu_op_e            op;
   logic [WORD_W-1:0]  w_val;
   logic [3:0]         w_cc;
   logic               w_wr;
   logic [H-1:0]       b_val;
   logic [3:0]         b_cc;
   logic               b_wr;
   logic [WORD_W-1:0]  swab_val;
   logic [WORD_W-1:0]  nx_result;
   logic [3:0]         nx_cc;
   logic               nx_wr;

   assign op = alu_op_e'(in_op);

   mmalu_lane #(.W(WORD_W)) u_word (
      .op     (op),
      .src    (in_src),
      .dst    (in_dst),
      .cc_in  (in_cc),
      .val    (w_val),
      .cc_out (w_cc),
      .wr     (w_wr)
   );

   mmalu_lane #(.W(H)) u_byte (
      .op     (op),
      .src    (in_src[H-1:0]),
      .dst    (in_dst[H-1:0]),
      .cc_in  (in_cc),
      .val    (b_val),
      .cc_out (b_cc),
      .wr     (b_wr)
   );

   assign swab_val = {in_dst[H-1:0], in_dst[WORD_W-1:H]};

   always_comb begin
      case (op)
         OP_SWAB: begin
            nx_result = swab_val;
            nx_cc     = {swab_val[H-1], (swab_val[H-1:0] == '0), 2'b00};
            nx_wr     = 1'b1;
         end
         OP_SXT: begin
            nx_result = {WORD_W{in_cc[CC_N]}};
            nx_cc     = {in_cc[CC_N], ~in_cc[CC_N], 1'b0, in_cc[CC_C]};
            nx_wr     = 1'b1;
         end
         default: begin
            if (in_byte) begin
               nx_result = b_wr ? {in_dst[WORD_W-1:H], b_val} : in_dst;
               nx_cc     = b_cc;
               nx_wr     = b_wr;
            end else begin
               nx_result = w_wr ? w_val : in_dst;
               nx_cc     = w_cc;
               nx_wr     = w_wr;
            end
         end
      endcase
   end

   generate
      if (REG_OUT == 1) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid  <= 1'b0;
               out_result <= '0;
               out_cc     <= '0;
               out_wr     <= 1'b0;
            end else begin
               out_valid  <= in_valid;
               out_result <= in_valid ? nx_result : '0;
               out_cc     <= in_valid ? nx_cc : 4'b0000;
               out_wr     <= in_valid & nx_wr;
            end
         end
      end else begin : g_comb
         assign out_valid  = in_valid;
         assign out_result = nx_result;
         assign out_cc     = nx_cc;
         assign out_wr     = in_valid & nx_wr;
      end
   endgenerate

endmodule

// File: rtl/mmalu_chk.sv
module mmalu_chk
   import mmalu_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int REG_OUT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [4:0]        in_op,
   input  logic              in_byte,
   input  logic [WORD_W-1:0] in_src,
   input  logic [WORD_W-1:0] in_dst,
   input  logic [3:0]        in_cc,
   input  logic              out_valid,
   input  logic [WORD_W-1:0] out_result,
   input  logic [3:0]        out_cc,
   input  logic              out_wr
);

   localparam int H = WORD_W / 2;

   logic is_noput;
   logic is_incdec;
   logic is_shift;
   logic is_logic;
   logic is_full;
   logic is_undef;

   assign is_noput  = (in_op == OP_CMP) || (in_op == OP_BIT) || (in_op == OP_TST);
   assign is_incdec = (in_op == OP_INC) || (in_op == OP_DEC);
   assign is_shift  = (in_op == OP_ROR) || (in_op == OP_ROL) ||
                      (in_op == OP_ASR) || (in_op == OP_ASL);
   assign is_logic  = (in_op == OP_MOV) || (in_op == OP_BIT) || (in_op == OP_BIC) ||
                      (in_op == OP_BIS) || (in_op == OP_XOR);
   assign is_full   = (in_op == OP_SWAB) || (in_op == OP_SXT);
   assign is_undef  = (in_op == 5'd14) || (in_op == 5'd15) || (in_op >= 5'd24);

   generate
      if (REG_OUT == 1) begin : g_props
         assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
         assert_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && is_noput) |=> (!out_wr && out_result == $past(in_dst)));
         assert_keep_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && is_incdec) |=> (out_cc[CC_C] == $past(in_cc[CC_C])));
         assert_com_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_op == OP_COM) |=> (out_cc[1:0] == 2'b01));
         assert_shift_v_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && is_shift) |=> (out_cc[CC_V] == (out_cc[CC_N] ^ out_cc[CC_C])));
         assert_logic_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && is_logic) |=>
               (!out_cc[CC_V] && out_cc[CC_C] == $past(in_cc[CC_C])));
         assert_swab_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_op == OP_SWAB) |=>
               (out_cc[1:0] == 2'b00 && out_cc[CC_N] == out_result[H-1]));
         assert_byte_upper_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_byte && !is_full) |=>
               (out_result[WORD_W-1:H] == $past(in_dst[WORD_W-1:H])));
         assert_undef_pass_R13: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && is_undef) |=> (!out_wr && out_cc == $past(in_cc)));
      end
   endgenerate

endmodule

bind mmalu mmalu_chk #(.WORD_W(WORD_W), .REG_OUT(REG_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_op      (in_op),
   .in_byte    (in_byte),
   .in_src     (in_src),
   .in_dst     (in_dst),
   .in_cc      (in_cc),
   .out_valid  (out_valid),
   .out_result (out_result),
   .out_cc     (out_cc),
   .out_wr     (out_wr)
);

// File: tb/mmalu_tb.sv
`timescale 1ns/1ps
module mmalu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  in_op = '0;
   logic        in_byte = 1'b0;
   logic [15:0] in_src = '0;
   logic [15:0] in_dst = '0;
   logic [3:0]  in_cc = '0;
   logic        out_valid;
   logic [15:0] out_result;
   logic [3:0]  out_cc;
   logic        out_wr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [15:0] res;
      logic [3:0]  cc;
      logic        wr;
      string       tag;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;

   mmalu u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_op      (in_op),
      .in_byte    (in_byte),
      .in_src     (in_src),
      .in_dst     (in_dst),
      .in_cc      (in_cc),
      .out_valid  (out_valid),
      .out_result (out_result),
      .out_cc     (out_cc),
      .out_wr     (out_wr)
   );

   localparam logic [4:0] CLR = 5'd0,  COM = 5'd1,  INC = 5'd2,  DEC = 5'd3,
                          NEG = 5'd4,  TST = 5'd5,  ROR = 5'd6,  ROL = 5'd7,
                          ASR = 5'd8,  ASL = 5'd9,  ADC = 5'd10, SBC = 5'd11,
                          SWB = 5'd12, SXT = 5'd13, MOV = 5'd16, CMP = 5'd17,
                          BIT = 5'd18, BIC = 5'd19, BIS = 5'd20, ADD = 5'd21,
                          SUB = 5'd22, XOR = 5'd23;

   task automatic push(input logic [4:0] op, input logic b, input logic [15:0] s,
                       input logic [15:0] d, input logic [3:0] c,
                       input logic [15:0] er, input logic [3:0] ec, input logic ew,
                       input string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = op;
      in_byte  = b;
      in_src   = s;
      in_dst   = d;
      in_cc    = c;
      e.res = er;
      e.cc  = ec;
      e.wr  = ew;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: pops one expectation per valid output
   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         if (sb.size() == 0) begin
            errors++;
            checks++;
            $display("FAIL R1: unexpected output res=%h cc=%b wr=%b, expected none",
                     out_result, out_cc, out_wr);
         end else begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (out_result !== e.res || out_cc !== e.cc || out_wr !== e.wr) begin
               errors++;
               $display("FAIL %s: res=%h cc=%b wr=%b, expected res=%h cc=%b wr=%b",
                        e.tag, out_result, out_cc, out_wr, e.res, e.cc, e.wr);
            end
         end
      end
   end

   initial begin
      #(4 * 50000);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      checks++;
      if (out_valid !== 1'b0 || out_result !== 16'h0 || out_cc !== 4'h0 || out_wr !== 1'b0) begin
         errors++;
         $display("FAIL R1: reset v=%b res=%h cc=%b wr=%b, expected all zero",
                  out_valid, out_result, out_cc, out_wr);
      end
      rst_n = 1'b1;

      // word operations
      push(MOV, 0, 16'o004711, 16'o123456, 4'b0000, 16'o004711, 4'b0000, 1, "R9");
      push(CMP, 0, 16'o004711, 16'o123456, 4'b0000, 16'o123456, 4'b0001, 0, "R3");
      push(CMP, 0, 16'o123456, 16'o004711, 4'b0000, 16'o004711, 4'b1000, 0, "R3");
      push(CMP, 0, 16'o004711, 16'o004711, 4'b0000, 16'o004711, 4'b0100, 0, "R3");
      push(CLR, 0, 16'o0,      16'o123456, 4'b1011, 16'o000000, 4'b0100, 1, "R2");
      push(BIT, 0, 16'o004711, 16'o000011, 4'b0000, 16'o000011, 4'b0000, 0, "R3");
      push(BIT, 0, 16'o004711, 16'o000066, 4'b0001, 16'o000066, 4'b0101, 0, "R9");
      push(BIC, 0, 16'o004711, 16'o123456, 4'b0000, 16'o123046, 4'b1000, 1, "R9");
      push(BIS, 0, 16'o004711, 16'o123456, 4'b0000, 16'o127757, 4'b1000, 1, "R9");
      push(ADD, 0, 16'o004711, 16'o123456, 4'b0000, 16'o130367, 4'b1000, 1, "R8");
      push(SUB, 0, 16'o004711, 16'o123456, 4'b0000, 16'o116545, 4'b1000, 1, "R8");
      push(COM, 0, 16'o0,      16'o123456, 4'b0000, 16'o054321, 4'b0001, 1, "R5");
      push(INC, 0, 16'o0,      16'o123456, 4'b0001, 16'o123457, 4'b1001, 1, "R4");
      push(DEC, 0, 16'o0,      16'o123456, 4'b0001, 16'o123455, 4'b1001, 1, "R4");
      push(NEG, 0, 16'o0,      16'o123456, 4'b0000, 16'o054322, 4'b0001, 1, "R5");
      push(TST, 0, 16'o0,      16'o123456, 4'b0001, 16'o123456, 4'b1000, 0, "R3");
      push(ROR, 0, 16'o0,      16'o100201, 4'b0000, 16'o040100, 4'b0011, 1, "R6");
      push(ROR, 0, 16'o0,      16'o002201, 4'b0001, 16'o101100, 4'b1001, 1, "R6");
      push(ROL, 0, 16'o0,      16'o100200, 4'b0001, 16'o000401, 4'b0011, 1, "R6");
      push(ASR, 0, 16'o0,      16'o000200, 4'b0000, 16'o000100, 4'b0000, 1, "R6");
      push(ASR, 0, 16'o0,      16'o100200, 4'b0000, 16'o140100, 4'b1010, 1, "R6");
      push(ASL, 0, 16'o0,      16'o000200, 4'b0000, 16'o000400, 4'b0000, 1, "R6");
      push(ASL, 0, 16'o0,      16'o100200, 4'b0000, 16'o000400, 4'b0011, 1, "R6");
      push(ADD, 0, 16'o004711, 16'o177000, 4'b0000, 16'o003711, 4'b0001, 1, "R8");
      push(ADC, 0, 16'o0,      16'o000200, 4'b0001, 16'o000201, 4'b0000, 1, "R7");
      push(SUB, 0, 16'o004711, 16'o004701, 4'b0000, 16'o177770, 4'b1001, 1, "R8");
      push(SBC, 0, 16'o0,      16'o000200, 4'b0001, 16'o000177, 4'b0000, 1, "R7");
      push(SWB, 0, 16'o0,      16'o111000, 4'b0111, 16'o000222, 4'b1000, 1, "R10");
      push(SXT, 0, 16'o0,      16'o111111, 4'b1000, 16'o177777, 4'b1000, 1, "R11");
      push(XOR, 0, 16'o004711, 16'o070707, 4'b0000, 16'o074016, 4'b0000, 1, "R9");
      push(SXT, 0, 16'o0,      16'o111111, 4'b0000, 16'o000000, 4'b0100, 1, "R11");
      // word boundaries
      push(INC, 0, 16'h0,    16'h7FFF, 4'b0000, 16'h8000, 4'b1010, 1, "R4");
      push(DEC, 0, 16'h0,    16'h8000, 4'b0000, 16'h7FFF, 4'b0010, 1, "R4");
      push(NEG, 0, 16'h0,    16'h8000, 4'b0000, 16'h8000, 4'b1011, 1, "R5");
      push(NEG, 0, 16'h0,    16'h0000, 4'b0001, 16'h0000, 4'b0100, 1, "R5");
      push(ADC, 0, 16'h0,    16'hFFFF, 4'b0001, 16'h0000, 4'b0101, 1, "R7");
      push(SBC, 0, 16'h0,    16'h0000, 4'b0001, 16'hFFFF, 4'b1001, 1, "R7");
      push(SBC, 0, 16'h0,    16'h8000, 4'b0001, 16'h7FFF, 4'b0010, 1, "R7");
      push(ADD, 0, 16'h0001, 16'h7FFF, 4'b0000, 16'h8000, 4'b1010, 1, "R8");
      push(SXT, 0, 16'h0,    16'h1234, 4'b1001, 16'hFFFF, 4'b1001, 1, "R11");
      push(MOV, 0, 16'h0000, 16'h1234, 4'b0001, 16'h0000, 4'b0101, 1, "R9");
      // byte operations, upper destination byte 5A must survive
      push(MOV, 1, 16'h0053, 16'h5ADB, 4'b0000, 16'h5A53, 4'b0000, 1, "R12");
      push(CMP, 1, 16'h0053, 16'h5ADB, 4'b0000, 16'h5ADB, 4'b0001, 0, "R12");
      push(BIC, 1, 16'h0053, 16'h5ADB, 4'b0000, 16'h5A88, 4'b1000, 1, "R12");
      push(COM, 1, 16'h0,    16'h5AD1, 4'b0000, 16'h5A2E, 4'b0001, 1, "R12");
      push(INC, 1, 16'h0,    16'h5AD1, 4'b0001, 16'h5AD2, 4'b1001, 1, "R12");
      push(NEG, 1, 16'h0,    16'h5AD1, 4'b0000, 16'h5A2F, 4'b0001, 1, "R12");
      push(ROR, 1, 16'h0,    16'h5A11, 4'b0001, 16'h5A88, 4'b1001, 1, "R12");
      push(ROL, 1, 16'h0,    16'h5A88, 4'b0001, 16'h5A11, 4'b0011, 1, "R12");
      push(ASR, 1, 16'h0,    16'h5A90, 4'b0000, 16'h5AC8, 4'b1010, 1, "R12");
      push(ASL, 1, 16'h0,    16'h5A90, 4'b0000, 16'h5A20, 4'b0011, 1, "R12");
      push(INC, 1, 16'h0,    16'h5A7F, 4'b0000, 16'h5A80, 4'b1010, 1, "R12");
      push(ADD, 1, 16'h0080, 16'h5A80, 4'b0000, 16'h5A00, 4'b0111, 1, "R12");
      push(SWB, 1, 16'h0,    16'h9200, 4'b0000, 16'h0092, 4'b1000, 1, "R10");
      push(SXT, 1, 16'h0,    16'h5A00, 4'b1000, 16'hFFFF, 4'b1000, 1, "R11");
      // undefined codes
      push(5'd14, 0, 16'h0F0F, 16'h1234, 4'b1011, 16'h1234, 4'b1011, 0, "R13");
      push(5'd31, 1, 16'h0F0F, 16'hABCD, 4'b0110, 16'hABCD, 4'b0110, 0, "R13");

      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      // R1 idle after request stream, queue must be drained
      checks++;
      if (out_valid !== 1'b0 || sb.size() != 0) begin
         errors++;
         $display("FAIL R1: idle out_valid=%b pending=%0d, expected 0 and 0",
                  out_valid, sb.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule